// File: doc/BRIEF.md
# Color-Tagged Tile Routing Switch

This block is the neighbour switch of one tile in a coarse-grained reconfigurable mesh. It has four sides, encoded North=0, East=1, South=2, West=3. Each side moves 32-bit words that carry a 2-bit color tag, and the four colors act as independent virtual channels. For every (color, side) pair the switch holds a receive head and a send head, which gives 16 slots of each kind. A slot index is formed as `{color, side}`.

Forwarding follows a rewritable table of rules. Each rule maps a (source side, color) pair to a destination side. A rule moves a word from the receive head to the send head of the same color on the destination side. The tile's processor core also reads receive heads and writes send heads. Here the core is represented by a plain read port and a plain write port. In each cycle the order is: ingress accepts arrivals, then rules fire, then core access, then egress drains the send heads.

Top module: `color_route_switch`

## Requirements
- R1: After reset, all receive and send heads are empty. `out_valid` is 0, `in_ready` is all ones, and `core_rd_ok` is 0.
- R2: `in_ready[d]` is high exactly when the receive head for (`in_color[d]`, d) is empty. A word is taken only on `in_valid & in_ready`. Otherwise it stays at the port.
- R3: A rule fires when its receive head is full and its destination send head is not busy. Firing empties the receive head and loads the same word into the send head, which becomes busy. A word accepted at clock edge k is presented at the egress after edge k+1.
- R4: Writing a rule whose source side and color match an existing rule replaces only that rule's destination. Any other write adds a new rule in the lowest free table entry.
- R5: Rules are evaluated in table order. When two rules target the same (color, destination) in one cycle, only the lower-indexed one fires, and the other word waits in its receive head.
- R6: A side's `out_valid` is high while any of its send heads is busy. The lowest busy color is presented first. A send head empties when the neighbour accepts its word (`out_valid & out_ready`), and `out_valid` holds while `out_ready` is low.
- R7: A busy send head blocks the rule that feeds it. The receive head keeps its word, and a new arrival of that color on that side sees `in_ready` low.
- R8: `core_rd_ok` is high when the selected receive head is full and no rule takes it in the same cycle. `core_rd_en` with `core_rd_ok` empties the head.
- R9: `core_wr_ok` is high when the selected send head is neither busy nor claimed by a rule in the same cycle. `core_wr_en` with `core_wr_ok` loads `core_wr_data` into it.
- R10: Colors are independent. A full receive head of one color does not lower `in_ready` for another color on the same side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | Arrival present, one bit per side |
| in_data | input | 128 | Arriving words, side d at bits [32d+31:32d] |
| in_color | input | 8 | Arrival colors, side d at bits [2d+1:2d] |
| in_ready | output | 4 | Arrival taken this cycle if valid |
| out_valid | output | 4 | Send word present, one bit per side |
| out_data | output | 128 | Outgoing words, per side |
| out_color | output | 8 | Outgoing colors, per side |
| out_ready | input | 4 | Neighbour accepts the outgoing word |
| cfg_we | input | 1 | Write one forwarding rule |
| cfg_src | input | 2 | Rule source side |
| cfg_dst | input | 2 | Rule destination side |
| cfg_color | input | 2 | Rule color |
| core_rd_en | input | 1 | Core pops the selected receive head |
| core_rd_dir | input | 2 | Core read side |
| core_rd_color | input | 2 | Core read color |
| core_rd_ok | output | 1 | Selected receive head is available to the core |
| core_rd_data | output | 32 | Word in the selected receive head |
| core_wr_en | input | 1 | Core loads the selected send head |
| core_wr_dir | input | 2 | Core write side |
| core_wr_color | input | 2 | Core write color |
| core_wr_data | input | 32 | Word to send |
| core_wr_ok | output | 1 | Selected send head may be written |

## Verification
Two conflicts can arise in the same cycle: a rule and the core both reaching for the same receive head, and a rule and the core both targeting the same send head. The bench provokes both at once. It arranges for a word to land in a receive head that has a rule pointing at an idle send head. In the cycle the rule fires, it selects that receive head on the core read port and that send head on the core write port, and both grant signals must read low. A second case loads two rules that compete for one send head, so that the table-order winner and the waiting word can be observed. The per-side scoreboard then confirms each word leaves exactly once, on the expected side and in the expected order.

// File: rtl/cr_pkg.sv
// Shared constants and types for the color-tagged routing switch.
// Assumes four sides and four colors; slot index is {color, side}.
package cr_pkg;
    localparam int N_DIR   = 4;
    localparam int N_COLOR = 4;
    localparam int DIR_W   = $clog2(N_DIR);
    localparam int COLOR_W = $clog2(N_COLOR);
    localparam int SLOT_W  = DIR_W + COLOR_W;
    localparam int N_SLOT  = N_DIR * N_COLOR;

    typedef enum logic [DIR_W-1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef struct packed {
        logic                vld;
        side_e               src;
        side_e               dst;
        logic [COLOR_W-1:0]  color;
    } fwd_rule_t;
endpackage

// File: rtl/cr_rule_table.sv
// Forwarding rule storage. A write that matches an existing
// (source, color) entry rewrites its destination; otherwise it fills the
// lowest free entry. Assumes entries are unique per (source, color).
module cr_rule_table
    import cr_pkg::*;
#(
    parameter int N_RULE = 16,
    localparam int IW = (N_RULE > 1) ? $clog2(N_RULE) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [DIR_W-1:0]          cfg_src,
    input  logic [DIR_W-1:0]          cfg_dst,
    input  logic [COLOR_W-1:0]        cfg_color,
    output fwd_rule_t [N_RULE-1:0]    rules
);
    logic          hit, has_free;
    logic [IW-1:0] hit_idx, free_idx;

    // Locate a matching entry and the lowest free entry.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < N_RULE; i++) begin
            if (!hit && rules[i].vld && rules[i].src == side_e'(cfg_src)
                && rules[i].color == cfg_color) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!has_free && !rules[i].vld) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // Apply a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rules <= '0;
        end else if (cfg_we) begin
            if (hit) begin
                rules[hit_idx].dst <= side_e'(cfg_dst);
            end else if (has_free) begin
                rules[free_idx] <= '{vld: 1'b1, src: side_e'(cfg_src),
                                     dst: side_e'(cfg_dst), color: cfg_color};
            end
        end
    end
endmodule

// File: rtl/cr_rule_fire.sv
// Combinational rule evaluator. Walks the table in order and fires each rule
// whose receive head is full and whose send head is idle and unclaimed.
// Assumes at most one rule per receive head.
module cr_rule_fire
    import cr_pkg::*;
#(
    parameter int N_RULE = 16
) (
    input  fwd_rule_t [N_RULE-1:0]              rules,
    input  logic [N_SLOT-1:0]                   rv,
    input  logic [N_SLOT-1:0]                   sb,
    output logic [N_SLOT-1:0]                   take,
    output logic [N_SLOT-1:0]                   claim,
    output logic [N_SLOT-1:0][SLOT_W-1:0]       src_of
);
    logic [SLOT_W-1:0] si [N_RULE];
    logic [SLOT_W-1:0] di [N_RULE];

    for (genvar i = 0; i < N_RULE; i++) begin : g_idx
        assign si[i] = {rules[i].color, rules[i].src};
        assign di[i] = {rules[i].color, rules[i].dst};
    end

    // In-order firing; earlier rules claim a send head first.
    always_comb begin
        take   = '0;
        claim  = '0;
        src_of = '0;
        for (int i = 0; i < N_RULE; i++) begin
            if (rules[i].vld && rv[si[i]] && !sb[di[i]] && !claim[di[i]]) begin
                take[si[i]]   = 1'b1;
                claim[di[i]]  = 1'b1;
                src_of[di[i]] = si[i];
            end
        end
    end
endmodule

// File: rtl/cr_egress_pick.sv
// Per-side egress selector: presents the lowest busy color.
// Assumes busy flags are registered state.
module cr_egress_pick
    import cr_pkg::*;
(
    input  logic [N_COLOR-1:0]  busy,
    output logic                valid,
    output logic [COLOR_W-1:0]  color
);
    // Fixed priority, color 0 highest.
    always_comb begin
        valid = |busy;
        color = '0;
        for (int c = N_COLOR - 1; c >= 0; c--) begin
            if (busy[c]) color = COLOR_W'(c);
        end
    end
endmodule

// File: rtl/color_route_switch.sv
// Tile neighbour switch with per-(color, side) receive and send heads,
// a rule table for forwarding, a core access port pair and a valid/ready
// egress per side. One cycle: ingress, rules, core, egress, all evaluated
// on start-of-cycle state with rules taking precedence over the core.
module color_route_switch
    import cr_pkg::*;
#(
    parameter int DW     = 32,
    parameter int N_RULE = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_DIR-1:0]            in_valid,
    input  logic [N_DIR*DW-1:0]         in_data,
    input  logic [N_DIR*COLOR_W-1:0]    in_color,
    output logic [N_DIR-1:0]            in_ready,
    output logic [N_DIR-1:0]            out_valid,
    output logic [N_DIR*DW-1:0]         out_data,
    output logic [N_DIR*COLOR_W-1:0]    out_color,
    input  logic [N_DIR-1:0]            out_ready,
    input  logic                        cfg_we,
    input  logic [DIR_W-1:0]            cfg_src,
    input  logic [DIR_W-1:0]            cfg_dst,
    input  logic [COLOR_W-1:0]          cfg_color,
    input  logic                        core_rd_en,
    input  logic [DIR_W-1:0]            core_rd_dir,
    input  logic [COLOR_W-1:0]          core_rd_color,
    output logic                        core_rd_ok,
    output logic [DW-1:0]               core_rd_data,
    input  logic                        core_wr_en,
    input  logic [DIR_W-1:0]            core_wr_dir,
    input  logic [COLOR_W-1:0]          core_wr_color,
    input  logic [DW-1:0]               core_wr_data,
    output logic                        core_wr_ok
);
    logic [N_SLOT-1:0]              rv, sb;
    logic [N_SLOT-1:0]              rv_take, sb_claim;
    logic [N_SLOT-1:0]              in_set, rd_clr, wr_set, drain;
    logic [N_SLOT-1:0][SLOT_W-1:0]  src_of;
    logic [DW-1:0]                  rh [N_SLOT];
    logic [DW-1:0]                  sh [N_SLOT];
    fwd_rule_t [N_RULE-1:0]         rules;
    logic [SLOT_W-1:0]              rd_slot, wr_slot;
    logic [N_COLOR-1:0]             side_busy [N_DIR];

    cr_rule_table #(.N_RULE(N_RULE)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_color(cfg_color), .rules(rules)
    );

    cr_rule_fire #(.N_RULE(N_RULE)) u_fire (
        .rules(rules), .rv(rv), .sb(sb),
        .take(rv_take), .claim(sb_claim), .src_of(src_of)
    );

    assign rd_slot = {core_rd_color, core_rd_dir};
    assign wr_slot = {core_wr_color, core_wr_dir};

    // Core access ranks after the rules of the same cycle.
    assign core_rd_ok   = rv[rd_slot] && !rv_take[rd_slot];
    assign core_rd_data = rh[rd_slot];
    assign core_wr_ok   = !sb[wr_slot] && !sb_claim[wr_slot];

    for (genvar d = 0; d < N_DIR; d++) begin : g_side
        // Arrival is taken only into an empty slot of its own color.
        assign in_ready[d] = !rv[{in_color[d*COLOR_W +: COLOR_W], DIR_W'(d)}];
        for (genvar c = 0; c < N_COLOR; c++) begin : g_col
            assign side_busy[d][c] = sb[c*N_DIR + d];
        end
        cr_egress_pick u_pick (
            .busy(side_busy[d]), .valid(out_valid[d]),
            .color(out_color[d*COLOR_W +: COLOR_W])
        );
        assign out_data[d*DW +: DW] = sh[{out_color[d*COLOR_W +: COLOR_W], DIR_W'(d)}];
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        localparam int D = s % N_DIR;
        localparam int C = s / N_DIR;
        assign in_set[s] = in_valid[D] && in_ready[D]
                           && (in_color[D*COLOR_W +: COLOR_W] == COLOR_W'(C));
        assign rd_clr[s] = core_rd_en && core_rd_ok && (rd_slot == SLOT_W'(s));
        assign wr_set[s] = core_wr_en && core_wr_ok && (wr_slot == SLOT_W'(s));
        assign drain[s]  = out_valid[D] && out_ready[D]
                           && (out_color[D*COLOR_W +: COLOR_W] == COLOR_W'(C));
    end

    // Occupancy flags for receive and send heads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv <= '0;
            sb <= '0;
        end else begin
            rv <= (rv & ~(rv_take | rd_clr)) | in_set;
            sb <= (sb & ~drain) | sb_claim | wr_set;
        end
    end

    // Head data: ingress and rule/core loads.
    always_ff @(posedge clk) begin
        for (int s = 0; s < N_SLOT; s++) begin
            if (in_set[s]) rh[s] <= in_data[(s % N_DIR)*DW +: DW];
            if (sb_claim[s])    sh[s] <= rh[src_of[s]];
            else if (wr_set[s]) sh[s] <= core_wr_data;
        end
    end
endmodule

// File: rtl/cr_switch_chk.sv
// Protocol checker for color_route_switch, bound to every instance.
// Observes ports and the head occupancy flags.
module cr_switch_chk
    import cr_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_DIR-1:0]          in_valid,
    input logic [N_DIR-1:0]          in_ready,
    input logic [N_DIR*COLOR_W-1:0]  in_color,
    input logic [N_DIR-1:0]          out_valid,
    input logic [N_DIR-1:0]          out_ready,
    input logic [N_DIR*COLOR_W-1:0]  out_color,
    input logic                      core_rd_en,
    input logic                      core_rd_ok,
    input logic [DIR_W-1:0]          core_rd_dir,
    input logic [COLOR_W-1:0]        core_rd_color,
    input logic                      core_wr_en,
    input logic                      core_wr_ok,
    input logic [DIR_W-1:0]          core_wr_dir,
    input logic [COLOR_W-1:0]        core_wr_color,
    input logic [N_SLOT-1:0]         rv,
    input logic [N_SLOT-1:0]         sb
);
    for (genvar d = 0; d < N_DIR; d++) begin : g_side
        // R6
        egress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[d] && !out_ready[d]) |=> out_valid[d]);
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        localparam int D = s % N_DIR;
        localparam int C = s / N_DIR;
        // R2
        ingress_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[D] && in_ready[D] && in_color[D*COLOR_W +: COLOR_W] == COLOR_W'(C))
            |=> rv[s]);
        // R6
        send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sb[s] && !(out_valid[D] && out_ready[D]
                        && out_color[D*COLOR_W +: COLOR_W] == COLOR_W'(C)))
            |=> sb[s]);
        // R8
        rd_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_rd_en && core_rd_ok && {core_rd_color, core_rd_dir} == SLOT_W'(s))
            |=> !rv[s]);
        // R9
        wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_wr_en && core_wr_ok && {core_wr_color, core_wr_dir} == SLOT_W'(s))
            |=> sb[s]);
    end
endmodule

bind color_route_switch cr_switch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_color(in_color), .out_valid(out_valid), .out_ready(out_ready),
    .out_color(out_color), .core_rd_en(core_rd_en), .core_rd_ok(core_rd_ok),
    .core_rd_dir(core_rd_dir), .core_rd_color(core_rd_color),
    .core_wr_en(core_wr_en), .core_wr_ok(core_wr_ok),
    .core_wr_dir(core_wr_dir), .core_wr_color(core_wr_color),
    .rv(rv), .sb(sb)
);

// File: tb/color_route_switch_test.sv
// Scoreboard bench: stimulus pushes expected (color, word) per side,
// a monitor pops on every egress handshake.
module color_route_switch_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   in_valid, in_ready, out_valid, out_ready;
    logic [127:0] in_data, out_data;
    logic [7:0]   in_color, out_color;
    logic         cfg_we;
    logic [1:0]   cfg_src, cfg_dst, cfg_color;
    logic         core_rd_en, core_rd_ok, core_wr_en, core_wr_ok;
    logic [1:0]   core_rd_dir, core_rd_color, core_wr_dir, core_wr_color;
    logic [31:0]  core_rd_data, core_wr_data;

    int checks = 0;
    int errors = 0;
    logic [33:0] q0[$], q1[$], q2[$], q3[$];

    color_route_switch uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_color(in_color), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_color(out_color), .out_ready(out_ready),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_color(cfg_color),
        .core_rd_en(core_rd_en), .core_rd_dir(core_rd_dir),
        .core_rd_color(core_rd_color), .core_rd_ok(core_rd_ok),
        .core_rd_data(core_rd_data), .core_wr_en(core_wr_en),
        .core_wr_dir(core_wr_dir), .core_wr_color(core_wr_color),
        .core_wr_data(core_wr_data), .core_wr_ok(core_wr_ok)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_out(input int side, input logic [1:0] col, input logic [31:0] w);
        case (side)
            0: q0.push_back({col, w});
            1: q1.push_back({col, w});
            2: q2.push_back({col, w});
            default: q3.push_back({col, w});
        endcase
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [1:0] d, input logic [1:0] c);
        cfg_we = 1'b1; cfg_src = s; cfg_dst = d; cfg_color = c;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic put(input int d, input logic [1:0] c, input logic [31:0] w);
        in_valid[d] = 1'b1;
        in_color[2*d +: 2] = c;
        in_data[32*d +: 32] = w;
    endtask

    // Drive one word and hold it until the handshake completes.
    task automatic send(input int d, input logic [1:0] c, input logic [31:0] w);
        put(d, c, w);
        @(negedge clk);
        while (!in_ready[d]) @(negedge clk);
        step();
        in_valid[d] = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare each egress transfer with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 4; d++) begin
                if (out_valid[d] && out_ready[d]) begin
                    logic [33:0] got, exp;
                    int n;
                    got = {out_color[2*d +: 2], out_data[32*d +: 32]};
                    case (d)
                        0: n = q0.size();
                        1: n = q1.size();
                        2: n = q2.size();
                        default: n = q3.size();
                    endcase
                    if (n == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R3/R6 side %0d unexpected actual=%h expected=none", d, got);
                    end else begin
                        case (d)
                            0: exp = q0.pop_front();
                            1: exp = q1.pop_front();
                            2: exp = q2.pop_front();
                            default: exp = q3.pop_front();
                        endcase
                        chk("R3/R6 egress word", got, exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        rst_n = 1'b0; in_valid = '0; in_data = '0; in_color = '0; out_ready = '0;
        cfg_we = 1'b0; cfg_src = '0; cfg_dst = '0; cfg_color = '0;
        core_rd_en = 1'b0; core_rd_dir = '0; core_rd_color = '0;
        core_wr_en = 1'b0; core_wr_dir = '0; core_wr_color = '0; core_wr_data = '0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 34'(out_valid), 34'h0);
        chk("R1 in_ready", 34'(in_ready), 34'hF);
        chk("R1 core_rd_ok", 34'(core_rd_ok), 34'h0);

        step();
        cfg(2'd3, 2'd1, 2'd0);       // entry 0: W c0 -> E
        cfg(2'd0, 2'd2, 2'd1);       // entry 1: N c1 -> S
        out_ready = 4'b0100;         // E held, S open

        // R3 latency and copy
        put(3, 2'd0, 32'hA1); expect_out(1, 2'd0, 32'hA1);
        put(0, 2'd1, 32'hB2); expect_out(2, 2'd1, 32'hB2);
        step();
        in_valid = '0;
        @(negedge clk);
        chk("R3 not yet at egress", 34'(out_valid[1]), 34'h0);
        @(negedge clk);
        chk("R3 egress after one more edge", {out_valid[1], out_color[3:2], out_data[63:32]},
            {1'b1, 2'd0, 32'hA1});

        // R7 backpressure, R10 color independence
        step();
        put(3, 2'd0, 32'hA2); expect_out(1, 2'd0, 32'hA2);
        step();
        in_valid = '0;
        step();
        in_color[7:6] = 2'd0; #1;
        chk("R7 in_ready low on full color", 34'(in_ready[3]), 34'h0);
        in_color[7:6] = 2'd2; #1;
        chk("R10 in_ready high on other color", 34'(in_ready[3]), 34'h1);
        chk("R7 send head holds", {out_valid[1], out_data[63:32]}, {1'b1, 32'hA1});
        expect_out(1, 2'd0, 32'hA3);
        fork
            send(3, 2'd0, 32'hA3);
            begin repeat (3) step(); out_ready[1] = 1'b1; end
        join
        repeat (6) step();
        chk("R7 east drained", 34'(q1.size()), 34'h0);

        // R4 rewrite destination
        cfg(2'd3, 2'd2, 2'd0);
        expect_out(2, 2'd0, 32'hC1);
        send(3, 2'd0, 32'hC1);
        repeat (4) step();
        chk("R4 routed to new side", 34'(q2.size()), 34'h0);

        // R5 table order conflict on (c3, S)
        cfg(2'd1, 2'd2, 2'd3);       // entry 2: E c3 -> S
        cfg(2'd0, 2'd2, 2'd3);       // entry 3: N c3 -> S
        out_ready[2] = 1'b0;
        put(1, 2'd3, 32'hD1); put(0, 2'd3, 32'hD2);
        expect_out(2, 2'd3, 32'hD1); expect_out(2, 2'd3, 32'hD2);
        step();
        in_valid = '0;
        repeat (2) step();
        chk("R5 lower entry wins", {out_color[5:4], out_data[95:64]}, {2'd3, 32'hD1});
        core_rd_dir = 2'd0; core_rd_color = 2'd3; #1;
        chk("R5 loser still waiting", {core_rd_ok, core_rd_data}, {1'b1, 32'hD2});
        out_ready[2] = 1'b1;
        repeat (5) step();
        chk("R5 both delivered", 34'(q2.size()), 34'h0);

        // R6 lowest color first
        out_ready[2] = 1'b0;
        put(0, 2'd1, 32'h11); put(1, 2'd3, 32'h33);
        expect_out(2, 2'd1, 32'h11); expect_out(2, 2'd3, 32'h33);
        step();
        in_valid = '0;
        repeat (2) step();
        chk("R6 lowest color presented", 34'(out_color[5:4]), 34'd1);
        out_ready[2] = 1'b1;
        repeat (4) step();

        // R8 core read and pop
        put(2, 2'd2, 32'hE5);
        step();
        in_valid = '0;
        core_rd_dir = 2'd2; core_rd_color = 2'd2; #1;
        chk("R8 core sees word", {core_rd_ok, core_rd_data}, {1'b1, 32'hE5});
        core_rd_en = 1'b1;
        step();
        core_rd_en = 1'b0; #1;
        chk("R8 head popped", 34'(core_rd_ok), 34'h0);

        // R8/R9 same-cycle conflict with a firing rule (W c0 -> S)
        put(3, 2'd0, 32'hF0); expect_out(2, 2'd0, 32'hF0);
        step();
        in_valid = '0;
        core_rd_dir = 2'd3; core_rd_color = 2'd0;
        core_wr_dir = 2'd2; core_wr_color = 2'd0; #1;
        chk("R8 rule wins receive head", 34'(core_rd_ok), 34'h0);
        chk("R9 rule wins send head", 34'(core_wr_ok), 34'h0);

        // R9 core write
        step();
        step();
        core_wr_dir = 2'd1; core_wr_color = 2'd2; core_wr_data = 32'h77; #1;
        chk("R9 write allowed", 34'(core_wr_ok), 34'h1);
        expect_out(1, 2'd2, 32'h77);
        core_wr_en = 1'b1;
        step();
        core_wr_en = 1'b0;
        repeat (10) step();
        chk("R6 all queues drained", 34'(q0.size() + q1.size() + q2.size() + q3.size()), 34'h0);
        chk("R6 egress idle", 34'(out_valid), 34'h0);
        report();
    end
endmodule